// File: doc/BRIEF.md
# Receive Buffer Credit Pause Tracker

This block keeps a running count of the receive buffers that software has handed to one DMA receive channel, and from that count decides whether the channel should request a pause from the link. Software posts buffers through a small register write port. A write to the allocation register either adds a number of buffers to the count or, when its top data bit is set, loads the count with an absolute value. The usual use of the load is to clear the count before the ring is filled. Each time the DMA engine fills a buffer it sends a one-cycle consume pulse, and the count drops by one.

The pause request uses hysteresis between two programmable thresholds. It is raised when the count falls below the low threshold. It is released only when the count climbs back to the high threshold or above it. Typical settings put the low threshold at one third of the ring and the high threshold at two thirds. A per-channel enable and a global DMA enable both gate the output. The count and the hysteresis state keep tracking while the output is gated. The current count is also brought out, so the receive logic can see how many buffers are posted.

Top module: `rx_credit_fc`

## Requirements
- R1: After reset the credit count, both thresholds and the pause state are zero, so `fc_req` is low.
- R2: A write with `reg_sel`=2 and `reg_wdata[31]`=0 adds `reg_wdata[CNT_W-1:0]` to the count. The sum saturates at 2^CNT_W-1, and data bits CNT_W..30 are ignored.
- R3: A write with `reg_sel`=2 and `reg_wdata[31]`=1 sets the count to `reg_wdata[CNT_W-1:0]` on the next edge. A consume pulse in the same cycle is discarded.
- R4: A `buf_used` pulse with no allocation write lowers the count by one. At zero the count stays at zero.
- R5: An add and a consume in the same cycle both apply. The new count is count+N-1, limited to the range 0..2^CNT_W-1.
- R6: `reg_sel`=0 writes the low threshold and `reg_sel`=1 writes the high threshold, each from `reg_wdata[CNT_W-1:0]`. A threshold takes part in comparisons from the cycle after it is written. A write with `reg_sel`=3 changes nothing.
- R7: The pause state becomes 1 on the edge at which the new count is below the low threshold.
- R8: The pause state becomes 0 on the edge at which the new count is at or above the high threshold, as long as the count is not also below the low threshold. In that case setting wins. Between the two thresholds the state holds.
- R9: `fc_req` equals the pause state only while `fc_chan_en` and `dma_glb_en` are both 1, and is 0 otherwise. The count and the pause state keep updating while the output is gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 low threshold, 1 high threshold, 2 allocation, 3 none |
| reg_wdata | input | DATA_W | Write data; top bit selects load on allocation writes |
| buf_used | input | 1 | One-cycle pulse, one buffer consumed by the DMA engine |
| fc_chan_en | input | 1 | Per-channel pause enable |
| dma_glb_en | input | 1 | Global DMA enable |
| credits | output | CNT_W | Current buffer credit count |
| fc_req | output | 1 | Pause request |

## Verification
The bench loads every start count of a 4-bit configuration and applies every add amount, both with and without a simultaneous consume. A counter that wrapped instead of saturating, or that dropped either half of a same-cycle add and consume, would give a wrong count on the next edge. The bench lowers the count through zero to catch an underflow to 15, and it issues a load together with a consume to catch a load that subtracts one. Slow ramps down and up through thresholds 5 and 10 check the hysteresis. A design without hysteresis would drop the request at count 5 instead of 10, and one that compared against the old count would switch one cycle late. Further sequences set the low threshold above the high one, toggle both enables while the count moves, and write with the unused select.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'd0,
    SEL_HIGH  = 2'd1,
    SEL_ALLOC = 2'd2,
    SEL_NONE  = 2'd3
  } rxfc_sel_e;

  // Saturating credit arithmetic: cur + add - dec, clamped to 0..maxv.
  function automatic logic [31:0] credit_step(input logic [31:0] cur,
                                               input logic [31:0] add,
                                               input logic        dec,
                                               input logic [31:0] maxv);
    logic [33:0] sum;
    sum = {2'b00, cur} + {2'b00, add};
    if (dec) begin
      if (sum == 34'd0) sum = 34'd0;
      else              sum = sum - 34'd1;
    end
    if (sum > {2'b00, maxv}) return maxv;
    return sum[31:0];
  endfunction

  // Hysteresis update: below-low sets (wins), at/above-high clears, else hold.
  function automatic logic hyst_next(input logic state,
                                     input logic below_low,
                                     input logic at_or_above_high);
    if (below_low)        return 1'b1;
    if (at_or_above_high) return 1'b0;
    return state;
  endfunction

endpackage

// File: rtl/rxfc_cfg_regs.sv
module rxfc_cfg_regs
  import rxfc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [CNT_W-1:0]  low_thr,
  output logic [CNT_W-1:0]  high_thr,
  output logic              add_evt,
  output logic              load_evt,
  output logic [CNT_W-1:0]  alloc_val
);
  localparam int LOAD_BIT = DATA_W - 1;

  rxfc_sel_e sel;
  logic      alloc_wr;
  logic      unused_mid;

  assign sel        = rxfc_sel_e'(reg_sel);
  assign alloc_wr   = reg_we && (sel == SEL_ALLOC);
  assign add_evt    = alloc_wr && !reg_wdata[LOAD_BIT];
  assign load_evt   = alloc_wr &&  reg_wdata[LOAD_BIT];
  assign alloc_val  = reg_wdata[CNT_W-1:0];
  assign unused_mid = ^reg_wdata[LOAD_BIT-1:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_thr  <= '0;
      high_thr <= '0;
    end else if (reg_we) begin
      case (sel)
        SEL_LOW:  low_thr  <= reg_wdata[CNT_W-1:0];
        SEL_HIGH: high_thr <= reg_wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rxfc_credit_ctr.sv
module rxfc_credit_ctr
  import rxfc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_evt,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] alloc_val,
  input  logic             use_evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  logic [31:0] step_res;
  logic [31:0] add_amt;

  assign add_amt  = add_evt ? 32'(alloc_val) : 32'd0;
  assign step_res = credit_step(32'(cnt_q), add_amt, use_evt, CNT_MAX);

  always_comb begin
    if (load_evt) cnt_d = alloc_val;
    else          cnt_d = step_res[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rxfc_hyst.sv
module rxfc_hyst
  import rxfc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] low_thr,
  input  logic [CNT_W-1:0] high_thr,
  input  logic             gate_en,
  output logic             state_q,
  output logic             fc_out
);
  logic below_low;
  logic reach_high;

  assign below_low  = cnt_d <  low_thr;
  assign reach_high = cnt_d >= high_thr;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= hyst_next(state_q, below_low, reach_high);
  end

  assign fc_out = state_q && gate_en;
endmodule

// File: rtl/rx_credit_fc.sv
module rx_credit_fc
  import rxfc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              buf_used,
  input  logic              fc_chan_en,
  input  logic              dma_glb_en,
  output logic [CNT_W-1:0]  credits,
  output logic              fc_req
);
  // Named internal events, visible to the bound checker.
  logic             add_evt;
  logic             load_evt;
  logic             use_evt;
  logic [CNT_W-1:0] alloc_val;
  logic [CNT_W-1:0] low_thr_w;
  logic [CNT_W-1:0] high_thr_w;
  logic [CNT_W-1:0] cnt_next;
  logic             fc_state_w;
  logic             gate_en;

  // A load is absolute: a consume in the same cycle is discarded.
  assign use_evt = buf_used && !load_evt;
  assign gate_en = fc_chan_en && dma_glb_en;

  rxfc_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .low_thr(low_thr_w), .high_thr(high_thr_w),
    .add_evt(add_evt), .load_evt(load_evt), .alloc_val(alloc_val)
  );

  rxfc_credit_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .add_evt(add_evt), .load_evt(load_evt),
    .alloc_val(alloc_val), .use_evt(use_evt), .cnt_q(credits), .cnt_d(cnt_next)
  );

  rxfc_hyst #(.CNT_W(CNT_W)) u_hyst (
    .clk(clk), .rst_n(rst_n), .cnt_d(cnt_next), .low_thr(low_thr_w),
    .high_thr(high_thr_w), .gate_en(gate_en), .state_q(fc_state_w), .fc_out(fc_req)
  );
endmodule

// File: rtl/rxfc_chk.sv
module rxfc_chk #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              buf_used,
  input logic              fc_chan_en,
  input logic              dma_glb_en,
  input logic [CNT_W-1:0]  credits,
  input logic              fc_state,
  input logic [CNT_W-1:0]  low_thr,
  input logic [CNT_W-1:0]  high_thr,
  input logic              fc_req
);
  logic alloc_wr;
  assign alloc_wr = reg_we && (reg_sel == 2'd2);

  a_r3_load_absolute: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_wr && reg_wdata[DATA_W-1] |=> credits == $past(reg_wdata[CNT_W-1:0]));

  a_r4_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (credits == '0) && !alloc_wr && buf_used |=> credits == '0);

  a_r4_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
    (credits != '0) && !alloc_wr && buf_used |=> credits == $past(credits) - 1'b1);

  a_r7_set_below_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fc_state) |-> credits < $past(low_thr));

  a_r8_clear_at_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fc_state) |-> credits >= $past(high_thr));

  a_r9_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(fc_chan_en && dma_glb_en) |-> !fc_req);
endmodule

bind rx_credit_fc rxfc_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .buf_used(buf_used), .fc_chan_en(fc_chan_en),
  .dma_glb_en(dma_glb_en), .credits(credits), .fc_state(fc_state_w),
  .low_thr(low_thr_w), .high_thr(high_thr_w), .fc_req(fc_req)
);

// File: tb/tb_rx_credit_fc.sv
`timescale 1ns/1ps
module tb_rx_credit_fc;
  localparam int CW  = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic        buf_used = 1'b0;
  logic        fc_chan_en = 1'b1;
  logic        dma_glb_en = 1'b1;
  logic [CW-1:0] credits;
  logic        fc_req;

  int total = 0;
  int bad = 0;
  int m_cnt = 0, m_low = 0, m_high = 0;
  bit m_fc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_credit_fc #(.CNT_W(CW), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .buf_used(buf_used), .fc_chan_en(fc_chan_en),
    .dma_glb_en(dma_glb_en), .credits(credits), .fc_req(fc_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock of stimulus, bench model update, then compare.
  task automatic step(input bit we, input int sel, input logic [31:0] d,
                      input bit used, input string tag);
    int nc;
    bit alloc;
    @(negedge clk);
    reg_we = we; reg_sel = sel[1:0]; reg_wdata = d; buf_used = used;
    alloc = we && (sel == 2);
    if (alloc && d[31]) nc = int'(d[CW-1:0]);
    else begin
      nc = m_cnt + (alloc ? int'(d[CW-1:0]) : 0) - (used ? 1 : 0);
      if (nc < 0) nc = 0;
      if (nc > MAXC) nc = MAXC;
    end
    if (nc < m_low) m_fc = 1;
    else if (nc >= m_high) m_fc = 0;
    if (we && sel == 0) m_low = int'(d[CW-1:0]);
    if (we && sel == 1) m_high = int'(d[CW-1:0]);
    m_cnt = nc;
    @(posedge clk); #1;
    check({tag, " count"}, int'(credits), m_cnt);
    check({tag, " fc"}, int'(fc_req), int'(m_fc && fc_chan_en && dma_glb_en));
    reg_we = 1'b0; buf_used = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1: reset values
    check("R1 count", int'(credits), 0);
    check("R1 fc", int'(fc_req), 0);
    @(negedge clk);

    // R2/R3/R5: exhaustive start x add x consume sweep
    for (int s = 0; s <= MAXC; s++)
      for (int n = 0; n <= MAXC; n++)
        for (int c = 0; c < 2; c++) begin
          step(1, 2, 32'h8000_0000 | 32'(s), 0, "R3 load");
          step(1, 2, 32'(n) | 32'h0000_0F00, c[0], c ? "R5 add+use" : "R2 add");
        end

    // R4: decrement through zero
    step(1, 2, 32'h8000_0002, 0, "R3 load");
    for (int i = 0; i < 4; i++) step(0, 3, 0, 1, "R4 consume");
    // R3: load with simultaneous consume discards the consume
    step(1, 2, 32'h8000_0007, 1, "R3 load+use");

    // R6: thresholds, and select 3 ignored
    step(1, 0, 32'd5, 0, "R6 low");
    step(1, 1, 32'd10, 0, "R6 high");
    step(1, 2, 32'h8000_000C, 0, "R3 load");
    step(1, 3, 32'h8000_0001, 0, "R6 sel3 ignored");
    // R7: ramp down, request rises below 5
    for (int i = 0; i < 12; i++) step(0, 3, 0, 1, "R7 ramp down");
    // R8: ramp up, request holds until 10
    for (int i = 0; i < 14; i++) step(1, 2, 32'd1, 0, "R8 ramp up");

    // R9: gating with state set
    step(1, 2, 32'h8000_0002, 0, "R7 set");
    fc_chan_en = 1'b0;
    step(0, 3, 0, 1, "R9 chan off");
    dma_glb_en = 1'b0;
    step(1, 2, 32'd12, 0, "R9 both off");
    fc_chan_en = 1'b1;
    step(1, 2, 32'h8000_0001, 0, "R9 glb off");
    dma_glb_en = 1'b1;
    step(0, 3, 0, 0, "R9 reenabled");

    // R8: low above high, below-low wins
    step(1, 1, 32'd3, 0, "R6 high");
    step(1, 0, 32'd8, 0, "R6 low");
    step(1, 2, 32'h8000_000F, 0, "R8 clear");
    step(1, 2, 32'h8000_0005, 0, "R8 set wins");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule